// File: doc/BRIEF.md
# Command-Sequenced Flash Save Controller

This block is the control logic of a byte-wide parallel flash that serves as save memory. The host writes bytes at 16-bit addresses. A fixed two-write unlock has to precede every command byte. The commands cover the identification mode, erase arming, whole-array erase, 4 KiB sector erase, single-byte programming and selection of a 64 KiB bank. Host reads return either the stored byte or the fixed identification bytes.

The storage itself sits outside the block, behind a single byte port with an asynchronous read. Programming and bank selection take effect in the cycle of the data write. The stored byte is read, ANDed with the new value and written back in that one cycle. An erase walks the array port one byte per cycle with the value 0xFF. The `busy` output is high while it runs, and host writes are dropped during that time. A configuration input gives the number of banks that are fitted.

Top module: `save_flash_ctrl`

## Requirements
- R1: The unlock is a write of 0xAA at address 0x5555 followed by a write of 0x55 at 0x2AAA. Any other second write returns the controller to idle. The write after a completed unlock is decoded as a command, at any address.
- R2: Command 0x90 turns identification mode on and 0xF0 turns it off. While the mode is on, `rd_data` is 0xBF at even addresses and 0xD4 at odd addresses. While it is off, `rd_data` is the stored byte.
- R3: Command 0x80 arms erase, and every command byte clears the arm. Commands 0x10 and 0x30 erase only when the arm was set by the command directly before them.
- R4: An armed 0x10 writes 0xFF to every byte of the fitted banks, which is `bank_cnt` × 65536 bytes. An armed 0x30 writes 0xFF to the 4096 bytes whose array address is {bank, command address bits [15:12], 12'h000}. The erase writes one byte per cycle, and `busy` is high from the cycle after the command until the erase ends. A whole-array erase of a single bank keeps `busy` high for 65536 cycles.
- R5: Command 0xA0 makes the next write a program. That write stores (old byte AND written byte) and then returns the controller to idle, so a further write changes nothing.
- R6: Command 0xB0 makes the next write a bank select. The bank becomes the written byte modulo `bank_cnt`, and the controller returns to idle.
- R7: Reads and programs use the array address bank × 65536 + 16-bit address.
- R8: Any other command byte has no effect and returns the controller to idle.
- R9: Reset returns the controller to idle, turns identification mode off, clears the arm and selects bank 0.
- R10: Host writes made while `busy` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host byte write strobe |
| wr_addr | input | 16 | Host write address |
| wr_data | input | 8 | Host write data |
| rd_addr | input | 16 | Host read address |
| rd_data | output | 8 | Host read data (combinational) |
| bank_cnt | input | BANK_W+1 | Number of fitted 64 KiB banks, 1 to 2**BANK_W |
| busy | output | 1 | Erase in progress |
| arr_addr | output | BANK_W+16 | Storage array address |
| arr_we | output | 1 | Storage array write enable |
| arr_wdata | output | 8 | Storage array write data |
| arr_rdata | input | 8 | Storage array read data (asynchronous) |

## Verification
The command decoder is driven with full unlocks, with an unlock whose second address is off by one, and with unlocks that end in an unknown byte. A following bare 0x90 then shows whether the controller really fell back to idle. Erase commands are issued once armed and once with a different command between the arm and the erase, which shows that only the directly preceding command counts. Preloaded bytes in the next sectors and in the other bank mark the edges of each erase, and a whole-array erase of one bank leaves the other bank intact. The bank select is given values above the bank count to exercise the modulo.

// File: rtl/save_flash_pkg.sv
`timescale 1ns/1ps
package save_flash_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_UNL1,
    ST_CMD,
    ST_BANK,
    ST_PROG
  } fl_state_e;

  localparam logic [15:0] UNLOCK_A1 = 16'h5555;
  localparam logic [7:0]  UNLOCK_D1 = 8'hAA;
  localparam logic [15:0] UNLOCK_A2 = 16'h2AAA;
  localparam logic [7:0]  UNLOCK_D2 = 8'h55;

  localparam logic [7:0] CMD_ID_ON  = 8'h90;
  localparam logic [7:0] CMD_ID_OFF = 8'hF0;
  localparam logic [7:0] CMD_ARM    = 8'h80;
  localparam logic [7:0] CMD_CHIP   = 8'h10;
  localparam logic [7:0] CMD_SECT   = 8'h30;
  localparam logic [7:0] CMD_PROG   = 8'hA0;
  localparam logic [7:0] CMD_BANK   = 8'hB0;

  localparam logic [7:0] ID_EVEN = 8'hBF;
  localparam logic [7:0] ID_ODD  = 8'hD4;
  localparam logic [7:0] ERASED  = 8'hFF;

  function automatic logic [7:0] id_byte(input logic odd);
    return odd ? ID_ODD : ID_EVEN;
  endfunction

  function automatic logic [7:0] prog_merge(input logic [7:0] old_b, input logic [7:0] new_b);
    return old_b & new_b;
  endfunction

  function automatic logic [7:0] mod8(input logic [7:0] val, input logic [7:0] cnt);
    return (cnt == 8'd0) ? 8'd0 : (val % cnt);
  endfunction

endpackage

// File: rtl/flash_cmd_fsm.sv
`timescale 1ns/1ps
module flash_cmd_fsm
  import save_flash_pkg::*;
#(
  parameter int BANK_W = 1,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_go,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [BANK_W:0]   cnt_eff,
  output fl_state_e         state,
  output logic              id_mode,
  output logic              armed,
  output logic [BANK_W-1:0] bank,
  output logic              prog_go,
  output logic              chip_go,
  output logic              sect_go
);

  logic [7:0]        bank_rem;
  logic [BANK_W-1:0] bank_nxt;
  logic              is_cmd;

  assign is_cmd   = wr_go && (state == ST_CMD);
  assign prog_go  = wr_go && (state == ST_PROG);
  assign chip_go  = is_cmd && armed && (wr_data == CMD_CHIP);
  assign sect_go  = is_cmd && armed && (wr_data == CMD_SECT);
  assign bank_rem = mod8(wr_data, 8'(cnt_eff));
  assign bank_nxt = bank_rem[BANK_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      id_mode <= 1'b0;
      armed   <= 1'b0;
      bank    <= '0;
    end else if (wr_go) begin
      case (state)
        ST_IDLE: begin
          if (wr_addr == UNLOCK_A1 && wr_data == UNLOCK_D1) state <= ST_UNL1;
        end
        ST_UNL1: begin
          state <= (wr_addr == UNLOCK_A2 && wr_data == UNLOCK_D2) ? ST_CMD : ST_IDLE;
        end
        ST_CMD: begin
          armed <= 1'b0;
          state <= ST_IDLE;
          case (wr_data)
            CMD_ID_ON:  id_mode <= 1'b1;
            CMD_ID_OFF: id_mode <= 1'b0;
            CMD_ARM:    armed   <= 1'b1;
            CMD_PROG:   state   <= ST_PROG;
            CMD_BANK:   state   <= ST_BANK;
            default:    ;
          endcase
        end
        ST_BANK: begin
          bank  <= bank_nxt;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/flash_erase_seq.sv
`timescale 1ns/1ps
module flash_erase_seq #(
  parameter int FULL_W = 17,
  parameter int SECT_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chip_go,
  input  logic              sect_go,
  input  logic [FULL_W-1:0] sect_base,
  input  logic [FULL_W-1:0] chip_last,
  output logic              busy,
  output logic              er_we,
  output logic [FULL_W-1:0] er_addr
);

  localparam logic [FULL_W-1:0] SECT_SPAN = FULL_W'((1 << SECT_W) - 1);

  logic [FULL_W-1:0] ptr;
  logic [FULL_W-1:0] last;

  assign er_we   = busy;
  assign er_addr = ptr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      ptr  <= '0;
      last <= '0;
    end else if (busy) begin
      if (ptr == last) busy <= 1'b0;
      else             ptr  <= ptr + 1'b1;
    end else if (chip_go) begin
      busy <= 1'b1;
      ptr  <= '0;
      last <= chip_last;
    end else if (sect_go) begin
      busy <= 1'b1;
      ptr  <= sect_base;
      last <= sect_base + SECT_SPAN;
    end
  end

endmodule

// File: rtl/save_flash_ctrl.sv
`timescale 1ns/1ps
module save_flash_ctrl
  import save_flash_pkg::*;
#(
  parameter int BANK_W = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [15:0]          wr_addr,
  input  logic [7:0]           wr_data,
  input  logic [15:0]          rd_addr,
  output logic [7:0]           rd_data,
  input  logic [BANK_W:0]      bank_cnt,
  output logic                 busy,
  output logic [BANK_W+15:0]   arr_addr,
  output logic                 arr_we,
  output logic [7:0]           arr_wdata,
  input  logic [7:0]           arr_rdata
);

  localparam int ADDR_W = 16;
  localparam int SECT_W = 12;
  localparam int FULL_W = BANK_W + ADDR_W;

  fl_state_e         fsm_st;
  logic              wr_go;
  logic              id_mode;
  logic              erase_armed;
  logic [BANK_W-1:0] bank;
  logic              prog_go;
  logic              chip_go;
  logic              sect_go;
  logic [BANK_W:0]   cnt_eff;
  logic [FULL_W:0]   span;
  logic [FULL_W-1:0] chip_last;
  logic [FULL_W-1:0] sect_base;
  logic              er_we;
  logic [FULL_W-1:0] er_addr;

  assign wr_go     = wr_en && !busy;
  assign cnt_eff   = (bank_cnt == '0) ? (BANK_W+1)'(1) : bank_cnt;
  assign span      = {cnt_eff, {ADDR_W{1'b0}}};
  assign chip_last = FULL_W'(span - 1'b1);
  assign sect_base = {bank, wr_addr[ADDR_W-1:SECT_W], {SECT_W{1'b0}}};

  flash_cmd_fsm #(.BANK_W(BANK_W), .ADDR_W(ADDR_W)) u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_go   (wr_go),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .cnt_eff (cnt_eff),
    .state   (fsm_st),
    .id_mode (id_mode),
    .armed   (erase_armed),
    .bank    (bank),
    .prog_go (prog_go),
    .chip_go (chip_go),
    .sect_go (sect_go)
  );

  flash_erase_seq #(.FULL_W(FULL_W), .SECT_W(SECT_W)) u_erase (
    .clk       (clk),
    .rst_n     (rst_n),
    .chip_go   (chip_go),
    .sect_go   (sect_go),
    .sect_base (sect_base),
    .chip_last (chip_last),
    .busy      (busy),
    .er_we     (er_we),
    .er_addr   (er_addr)
  );

  always_comb begin
    if (er_we) begin
      arr_addr  = er_addr;
      arr_we    = 1'b1;
      arr_wdata = ERASED;
    end else if (prog_go) begin
      arr_addr  = {bank, wr_addr};
      arr_we    = 1'b1;
      arr_wdata = prog_merge(arr_rdata, wr_data);
    end else begin
      arr_addr  = {bank, rd_addr};
      arr_we    = 1'b0;
      arr_wdata = 8'h00;
    end
  end

  assign rd_data = id_mode ? id_byte(rd_addr[0]) : arr_rdata;

endmodule

// File: rtl/save_flash_chk.sv
`timescale 1ns/1ps
module save_flash_chk
  import save_flash_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      busy,
  input logic      wr_en,
  input logic [7:0] wr_data,
  input fl_state_e st,
  input logic      armed,
  input logic      id_mode,
  input logic      chip_go,
  input logic      sect_go,
  input logic      prog_go,
  input logic      arr_we,
  input logic [7:0] arr_wdata,
  input logic [7:0] rd_data
);

  p_unlock_path_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_CMD && $past(st) != ST_CMD) |-> $past(st) == ST_UNL1);

  p_id_bytes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    id_mode |-> (rd_data == ID_EVEN || rd_data == ID_ODD));

  p_erase_needs_arm_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_go || sect_go) |-> armed);

  p_arm_cleared_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_CMD && wr_en && !busy && wr_data != CMD_ARM) |=> !armed);

  p_erase_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_go || sect_go) |=> busy);

  p_erase_value_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && arr_we) |-> arr_wdata == ERASED);

  p_prog_returns_r5: assert property (@(posedge clk) disable iff (!rst_n)
    prog_go |=> st == ST_IDLE);

  p_busy_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(st) && $stable(armed) && $stable(id_mode)));

endmodule

bind save_flash_ctrl save_flash_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .wr_en     (wr_en),
  .wr_data   (wr_data),
  .st        (fsm_st),
  .armed     (erase_armed),
  .id_mode   (id_mode),
  .chip_go   (chip_go),
  .sect_go   (sect_go),
  .prog_go   (prog_go),
  .arr_we    (arr_we),
  .arr_wdata (arr_wdata),
  .rd_data   (rd_data)
);

// File: tb/save_flash_ctrl_bench.sv
`timescale 1ns/1ps
module save_flash_ctrl_bench;

  localparam int BANK_W = 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic [15:0]       wr_addr = '0;
  logic [7:0]        wr_data = '0;
  logic [15:0]       rd_addr = '0;
  logic [7:0]        rd_data;
  logic [BANK_W:0]   bank_cnt = 2'd2;
  logic              busy;
  logic [BANK_W+15:0] arr_addr;
  logic              arr_we;
  logic [7:0]        arr_wdata;
  logic [7:0]        arr_rdata;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  int gen = 0;
  bit done = 1'b0;

  logic [7:0] mem [int unsigned];
  logic [7:0] exp_q [$];
  string      tag_q [$];

  always #4 clk = ~clk;

  save_flash_ctrl #(.BANK_W(BANK_W)) u_save_flash_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .bank_cnt(bank_cnt), .busy(busy),
    .arr_addr(arr_addr), .arr_we(arr_we), .arr_wdata(arr_wdata), .arr_rdata(arr_rdata)
  );

  // storage model: asynchronous read, unwritten bytes read 0x00
  always @(posedge clk) begin
    if (arr_we) begin
      mem[int'(arr_addr)] = arr_wdata;
      gen = gen + 1;
    end
  end

  always @(arr_addr or gen) begin
    arr_rdata = mem.exists(int'(arr_addr)) ? mem[int'(arr_addr)] : 8'h00;
  end

  // monitor: pops one expected byte per read issued by the driver
  always @(negedge clk) begin
    if (exp_q.size() != 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      tests++;
      if (rd_data !== e) begin
        fails++;
        $display("FAIL %s: addr %h got %h expected %h", t, rd_addr, rd_data, e);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog: cycle %0d expected finish before 150000", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic poke(input int unsigned a, input logic [7:0] d);
    mem[a] = d;
    gen = gen + 1;
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic cmd(input logic [15:0] a, input logic [7:0] c);
    wr(16'h5555, 8'hAA);
    wr(16'h2AAA, 8'h55);
    wr(a, c);
  endtask

  task automatic rd_chk(input logic [15:0] a, input logic [7:0] e, input string t);
    @(posedge clk); #1;
    rd_addr = a;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk); #1;
  endtask

  task automatic chk(input bit ok, input int act, input int e, input string t);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", t, act, e);
    end
  endtask

  task automatic busy_len(output int n);
    n = 0;
    for (int i = 0; i < 70000; i++) begin
      @(negedge clk);
      if (!busy) break;
      n++;
    end
  endtask

  initial begin
    int n;
    poke(32'h00123, 8'hF0);
    poke(32'h10123, 8'hA5);
    poke(32'h04010, 8'h11);
    poke(32'h05000, 8'h22);
    poke(32'h05FFF, 8'h33);
    poke(32'h06000, 8'h44);
    poke(32'h15000, 8'h55);
    poke(32'h00ABC, 8'h6C);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R9 reset state: bank 0, array data, not busy
    @(negedge clk);
    chk(busy == 1'b0, busy, 0, "R9 busy after reset");
    rd_chk(16'h0123, 8'hF0, "R9 bank0 array read");
    rd_chk(16'h0ABC, 8'h6C, "R9 array read second");

    // R2 identification mode
    cmd(16'h0000, 8'h90);
    rd_chk(16'h0000, 8'hBF, "R2 id even");
    rd_chk(16'h0001, 8'hD4, "R2 id odd");
    rd_chk(16'h0123, 8'hD4, "R2 id odd high");
    cmd(16'h0000, 8'hF0);
    rd_chk(16'h0123, 8'hF0, "R2 id exit");

    // R1 wrong second unlock step
    wr(16'h5555, 8'hAA);
    wr(16'h2AAB, 8'h55);
    wr(16'h0000, 8'h90);
    rd_chk(16'h0ABC, 8'h6C, "R1 bad unlock ignored");

    // R5 program clears bits only, then idle
    cmd(16'h0000, 8'hA0);
    wr(16'h0123, 8'h3C);
    rd_chk(16'h0123, 8'h30, "R5 program AND");
    wr(16'h0123, 8'h00);
    rd_chk(16'h0123, 8'h30, "R5 back to idle");

    // R6 / R7 bank select with modulo
    cmd(16'h0000, 8'hB0);
    wr(16'h0000, 8'h03);
    rd_chk(16'h0123, 8'hA5, "R6 bank 3 mod 2");
    cmd(16'h0000, 8'hA0);
    wr(16'h0123, 8'h0F);
    rd_chk(16'h0123, 8'h05, "R7 program in bank1");
    cmd(16'h0000, 8'hB0);
    wr(16'h0000, 8'h02);
    rd_chk(16'h0123, 8'h30, "R7 bank0 unaffected");

    // R3 unarmed and disarmed erase do nothing
    cmd(16'h5000, 8'h30);
    @(negedge clk);
    chk(busy == 1'b0, busy, 0, "R3 unarmed sector erase");
    rd_chk(16'h5000, 8'h22, "R3 unarmed data kept");
    cmd(16'h0000, 8'h80);
    cmd(16'h0000, 8'h90);
    cmd(16'h5000, 8'h30);
    @(negedge clk);
    chk(busy == 1'b0, busy, 0, "R3 arm cleared by other command");
    cmd(16'h0000, 8'hF0);
    rd_chk(16'h5000, 8'h22, "R3 disarmed data kept");

    // R8 unknown command returns to idle
    cmd(16'h0000, 8'h77);
    wr(16'h0000, 8'h90);
    rd_chk(16'h0ABC, 8'h6C, "R8 unknown command ignored");

    // R4 sector erase, R10 writes during busy
    cmd(16'h0000, 8'h80);
    cmd(16'h5123, 8'h30);
    @(negedge clk);
    chk(busy == 1'b1, busy, 1, "R4 busy after sector command");
    cmd(16'h0000, 8'h90);
    busy_len(n);
    rd_chk(16'h5000, 8'hFF, "R4 sector first byte");
    rd_chk(16'h5FFF, 8'hFF, "R4 sector last byte");
    rd_chk(16'h4010, 8'h11, "R4 lower sector kept");
    rd_chk(16'h6000, 8'h44, "R4 upper sector kept");
    rd_chk(16'h0ABC, 8'h6C, "R10 command during busy ignored");
    cmd(16'h0000, 8'hB0);
    wr(16'h0000, 8'h01);
    rd_chk(16'h5000, 8'h55, "R4 other bank sector kept");
    cmd(16'h0000, 8'hB0);
    wr(16'h0000, 8'h00);

    // R4 chip erase over one fitted bank
    bank_cnt = 2'd1;
    cmd(16'h0000, 8'h80);
    cmd(16'h0000, 8'h10);
    busy_len(n);
    chk(n == 65536, n, 65536, "R4 chip erase length");
    rd_chk(16'h0123, 8'hFF, "R4 chip erased a");
    rd_chk(16'h0ABC, 8'hFF, "R4 chip erased b");
    rd_chk(16'h4010, 8'hFF, "R4 chip erased c");
    bank_cnt = 2'd2;
    cmd(16'h0000, 8'hB0);
    wr(16'h0000, 8'h01);
    rd_chk(16'h0123, 8'h05, "R4 unfitted bank kept");

    // R9 reset mid-use: id mode and arm set, bank 1
    cmd(16'h0000, 8'h90);
    cmd(16'h0000, 8'h80);
    @(posedge clk); #1 rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    rd_chk(16'h0123, 8'hFF, "R9 id off and bank0");
    cmd(16'h0000, 8'h30);
    @(negedge clk);
    chk(busy == 1'b0, busy, 0, "R9 arm cleared by reset");

    repeat (2) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule